// File: doc/BRIEF.md
# Single-Level Page Translator with Translation Cache

This block turns a 32-bit linear address into a 32-bit physical address. The upper 20 bits of the linear address are a page number and the low 12 bits are an offset that is never altered. The page number is looked up in a four-entry fully associative translation cache. On a hit the result comes back one cycle later, with no memory traffic. On a miss the block fetches one 32-bit page-table word from memory at the table base plus four times the page number. The table base is an input driven by a control register. If the word is present, the block splices its frame number onto the offset and caches the mapping. If it is not present, the block reports a page fault.

Switching to another address space means writing a new table base. The base write, or a separate flush pulse, drops every cached mapping so that the same page can resolve to a different frame under the new table. A requester presents one request at a time while the block is idle and receives a single-cycle completion pulse. The memory side is a valid/ready read request with a response-valid return of arbitrary latency.

Top module: `lin2phys_xlate`

## Requirements
- R1: A request accepted while the page is cached gives `done` high in the very next cycle, for exactly one cycle, with `done_fault` low and `done_paddr` = {cached frame, linear[11:0]}. No memory request is made.
- R2: A request that misses the cache makes exactly one memory read, at address `ptbase + linear[31:12]*4`, using the base value present in the cycle the request is accepted.
- R3: For a table word with bit 0 set, the result is {word[31:12], linear[11:0]}. Bits [11:1] of the word have no effect.
- R4: For a table word with bit 0 clear, `done_fault` is high and `done_paddr` is zero. Such a word is never cached, so repeating the access reads memory again.
- R5: A present mapping fetched by a walk is cached, so that a later request to the same page hits.
- R6: A new mapping goes into the lowest-numbered empty entry. When all four entries are full, it goes into the entry named by a round-robin pointer. The pointer starts at entry 0 after reset or invalidation and advances by one on each such eviction.
- R7: A `flush` pulse or a `ptbase_wr` pulse empties the cache at the next clock edge. A request accepted in that same cycle is handled as a miss. The result of a walk that was in flight during the pulse is returned but not cached.
- R8: `req_ready` is high only while idle. A `req_valid` raised during a walk is ignored and produces no completion.
- R9: The memory request stays asserted, with a stable address, until `mem_req_ready`. The block then waits any number of cycles for `mem_rsp_valid`. `mem_rsp_valid` outside that wait is ignored.
- R10: After reset, `req_ready` is high, `done` and `mem_req_valid` are low, and the cache is empty.
- R11: After the base changes, a page translates through the new table even if it was cached under the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle; request accepted when both high |
| req_laddr | input | 32 | Linear address to translate |
| ptbase | input | 32 | Page-table base address |
| ptbase_wr | input | 1 | Pulse in the first cycle a new base appears |
| flush | input | 1 | Pulse to empty the translation cache |
| done | output | 1 | One-cycle completion pulse |
| done_paddr | output | 32 | Physical address (zero on fault) |
| done_fault | output | 1 | Page fault indication with `done` |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the table word |
| mem_rsp_valid | input | 1 | Table word returned |
| mem_rsp_data | input | 32 | Table word: [31:12] frame, [0] present |

## Verification
Cache invalidation and cache use can land in the same cycle in two ways. A flush can coincide with a lookup: a request is accepted in the very cycle `flush` is high, and the bench expects a memory read and a miss latency, not a one-cycle hit. A flush can also overlap the fill of a walk: `flush` is pulsed while a long-latency read is outstanding, and the bench expects the correct address back but a second memory read on the next access to that page. Base writes between sweeps over both tables check the same invalidation through the frames returned.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_ISSUE = 2'd1,
    W_WAIT  = 2'd2
  } walk_state_e;

endpackage

// File: rtl/xlate_cam.sv
module xlate_cam #(
  parameter int PN_W  = 20,
  parameter int FN_W  = 20,
  parameter int N_ENT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PN_W-1:0] lk_pn,
  output logic            lk_hit,
  output logic [FN_W-1:0] lk_frame,
  input  logic            inv,
  input  logic            fill_en,
  input  logic [PN_W-1:0] fill_pn,
  input  logic [FN_W-1:0] fill_frame
);

  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  logic [N_ENT-1:0] vld_q, vld_d;
  logic [N_ENT-1:0] match;
  logic [N_ENT-1:0] we;
  logic [FN_W-1:0]  frm_sel [N_ENT];
  logic [IDX_W-1:0] rr_q, rr_d;
  logic [IDX_W-1:0] victim;
  logic             any_free;

  // per-entry storage, tag compare and frame select
  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic [PN_W-1:0] tag_q;
    logic [FN_W-1:0] frm_q;
    always_ff @(posedge clk) begin
      if (we[i]) begin
        tag_q <= fill_pn;
        frm_q <= fill_frame;
      end
    end
    assign match[i]   = vld_q[i] && (tag_q == lk_pn);
    assign frm_sel[i] = match[i] ? frm_q : '0;
  end

  // a lookup in an invalidation cycle must not use old contents
  always_comb begin
    lk_hit   = (|match) && !inv;
    lk_frame = '0;
    for (int i = 0; i < N_ENT; i++) lk_frame = lk_frame | frm_sel[i];
  end

  // victim: lowest empty entry, else the round-robin pointer
  always_comb begin
    victim   = rr_q;
    any_free = 1'b0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        victim   = IDX_W'(i);
        any_free = 1'b1;
      end
    end
    for (int i = 0; i < N_ENT; i++) we[i] = fill_en && !inv && (victim == IDX_W'(i));
  end

  always_comb begin
    vld_d = vld_q;
    rr_d  = rr_q;
    if (inv) begin
      vld_d = '0;
      rr_d  = '0;
    end else if (fill_en) begin
      vld_d = vld_q | we;
      if (!any_free) rr_d = (rr_q == IDX_W'(N_ENT - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      vld_q <= vld_d;
      rr_q  <= rr_d;
    end
  end

  // R7: an invalidation leaves every entry empty at the next edge
  p_inv_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inv |=> (vld_q == '0));

  // R5: a page is never held in two entries
  p_single_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R6: the pointer only moves when a full cache takes a fill
  p_rr_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!inv && !(fill_en && (vld_q == '1))) |=> $stable(rr_q));

endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import xlate_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 12,
  parameter int PTE_SHIFT = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_laddr,
  input  logic [ADDR_W-1:0]     ptbase,
  input  logic                  inv,
  input  logic                  lk_hit,
  input  logic [ADDR_W-OFF_W-1:0] lk_frame,
  output logic                  fill_en,
  output logic [ADDR_W-OFF_W-1:0] fill_pn,
  output logic [ADDR_W-OFF_W-1:0] fill_frame,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [ADDR_W-1:0]     mem_req_addr,
  input  logic                  mem_rsp_valid,
  input  logic [ADDR_W-1:0]     mem_rsp_data,
  output logic                  done,
  output logic [ADDR_W-1:0]     done_paddr,
  output logic                  done_fault
);

  localparam int PN_W = ADDR_W - OFF_W;

  walk_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [PN_W-1:0]   pn_q;
  logic [OFF_W-1:0]  off_q;
  logic              stale_q, stale_d;
  logic              done_q, done_d;
  logic [ADDR_W-1:0] paddr_q, paddr_d;
  logic              fault_q, fault_d;
  logic              accept, cap_en, rsp_take;
  logic [PN_W-1:0]   req_pn;
  logic [ADDR_W-1:0] entry_addr;
  logic              unused_pte_bits;

  assign req_pn          = req_laddr[ADDR_W-1:OFF_W];
  assign entry_addr      = ptbase + (ADDR_W'(req_pn) << PTE_SHIFT);
  assign unused_pte_bits = ^mem_rsp_data[OFF_W-1:1];

  always_comb begin
    state_d       = state_q;
    req_ready     = (state_q == W_IDLE);
    accept        = req_ready && req_valid;
    cap_en        = 1'b0;
    mem_req_valid = 1'b0;
    rsp_take      = 1'b0;
    done_d        = 1'b0;
    paddr_d       = '0;
    fault_d       = 1'b0;
    case (state_q)
      W_IDLE: begin
        if (accept) begin
          if (lk_hit) begin
            done_d  = 1'b1;
            paddr_d = {lk_frame, req_laddr[OFF_W-1:0]};
          end else begin
            cap_en  = 1'b1;
            state_d = W_ISSUE;
          end
        end
      end
      W_ISSUE: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) state_d = W_WAIT;
      end
      W_WAIT: begin
        if (mem_rsp_valid) begin
          rsp_take = 1'b1;
          done_d   = 1'b1;
          state_d  = W_IDLE;
          if (mem_rsp_data[0]) paddr_d = {mem_rsp_data[ADDR_W-1:OFF_W], off_q};
          else                 fault_d = 1'b1;
        end
      end
      default: state_d = W_IDLE;
    endcase
  end

  // a walk that saw an invalidation must not fill the cache
  always_comb begin
    stale_d = stale_q;
    if (cap_en)                          stale_d = 1'b0;
    else if (inv && (state_q != W_IDLE)) stale_d = 1'b1;
  end

  assign fill_en      = rsp_take && mem_rsp_data[0] && !stale_q && !inv;
  assign fill_pn      = pn_q;
  assign fill_frame   = mem_rsp_data[ADDR_W-1:OFF_W];
  assign mem_req_addr = addr_q;
  assign done         = done_q;
  assign done_paddr   = paddr_q;
  assign done_fault   = fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= W_IDLE;
      stale_q <= 1'b0;
      done_q  <= 1'b0;
      paddr_q <= '0;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      stale_q <= stale_d;
      done_q  <= done_d;
      if (done_d) begin
        paddr_q <= paddr_d;
        fault_q <= fault_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q <= entry_addr;
      pn_q   <= req_pn;
      off_q  <= req_laddr[OFF_W-1:0];
    end
  end

  // R9: a stalled table read keeps its request and address
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R1: a hit completes in the next cycle without a fault
  p_hit_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && lk_hit) |=> (done && !done_fault));

  // R2: a returned table word ends the walk in the next cycle
  p_walk_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && !req_ready && !mem_req_valid) |=> done);

  // R8: never ready for a new request while a read is pending
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R4: a fault carries a zero address
  p_fault_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fault) |-> (done_paddr == '0));

endmodule

// File: rtl/lin2phys_xlate.sv
module lin2phys_xlate #(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 12,
  parameter int N_ENT     = 4,
  parameter int PTE_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_laddr,
  input  logic [ADDR_W-1:0] ptbase,
  input  logic              ptbase_wr,
  input  logic              flush,
  output logic              done,
  output logic [ADDR_W-1:0] done_paddr,
  output logic              done_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data
);

  localparam int PN_W = ADDR_W - OFF_W;

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic            inv;
  logic            lk_hit;
  logic [PN_W-1:0] lk_frame;
  logic            fill_en;
  logic [PN_W-1:0] fill_pn;
  logic [PN_W-1:0] fill_frame;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign inv = flush || ptbase_wr;

  xlate_cam #(
    .PN_W  (PN_W),
    .FN_W  (PN_W),
    .N_ENT (N_ENT)
  ) u_cam (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .lk_pn      (req_laddr[ADDR_W-1:OFF_W]),
    .lk_hit     (lk_hit),
    .lk_frame   (lk_frame),
    .inv        (inv),
    .fill_en    (fill_en),
    .fill_pn    (fill_pn),
    .fill_frame (fill_frame)
  );

  xlate_walker #(
    .ADDR_W    (ADDR_W),
    .OFF_W     (OFF_W),
    .PTE_SHIFT (PTE_SHIFT)
  ) u_walk (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_laddr     (req_laddr),
    .ptbase        (ptbase),
    .inv           (inv),
    .lk_hit        (lk_hit),
    .lk_frame      (lk_frame),
    .fill_en       (fill_en),
    .fill_pn       (fill_pn),
    .fill_frame    (fill_frame),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .done          (done),
    .done_paddr    (done_paddr),
    .done_fault    (done_fault)
  );

endmodule

// File: tb/lin2phys_xlate_bench.sv
`timescale 1ns/1ps
module lin2phys_xlate_bench;

  localparam logic [31:0] BASE_A = 32'h1000_0000;
  localparam logic [31:0] BASE_B = 32'h2000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [31:0] req_laddr, ptbase;
  logic        ptbase_wr, flush;
  logic        done, done_fault;
  logic [31:0] done_paddr;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  always #2 clk = ~clk;

  lin2phys_xlate u_lin2phys_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_laddr(req_laddr), .ptbase(ptbase), .ptbase_wr(ptbase_wr), .flush(flush),
    .done(done), .done_paddr(done_paddr), .done_fault(done_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  int vectors = 0;
  int fails   = 0;
  bit base_sel = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // page-table contents, computed per table
  function automatic logic [31:0] pte_of(input bit b, input logic [19:0] pn);
    logic [19:0] fr;
    bit          pr;
    if (!b) begin fr = pn ^ 20'h0A5C3; pr = (pn % 5) != 3; end
    else    begin fr = pn + 20'h12345; pr = (pn % 4) != 2; end
    return {fr, pn[10:0] ^ 11'h2D6, pr};
  endfunction

  // memory model
  int          reads = 0;
  bit          hs_flag = 0, busy = 0;
  logic [31:0] hs_addr = '0;
  int          lat_cnt = 0, lat_knob = 0, stall_knob = 0, stall_cnt = 0;

  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready) begin
      hs_flag = 1;
      hs_addr = mem_req_addr;
      reads++;
    end
  end

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'hDEAD_BEEF;
    if (busy) begin
      if (lat_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = pte_of(hs_addr[31:28] == 4'h2, hs_addr[21:2]);
        busy = 0;
      end else lat_cnt--;
    end
    if (hs_flag) begin hs_flag = 0; busy = 1; lat_cnt = lat_knob; end
    mem_req_ready = mem_req_valid && (stall_cnt >= stall_knob);
    stall_cnt = mem_req_valid ? stall_cnt + 1 : 0;
  end

  // cache model built from the replacement rule
  bit          m_vld [4];
  logic [19:0] m_pn  [4];
  int          m_rr = 0;

  function automatic void m_flush();
    for (int i = 0; i < 4; i++) m_vld[i] = 0;
    m_rr = 0;
  endfunction

  function automatic bit m_hit(input logic [19:0] pn);
    for (int i = 0; i < 4; i++) if (m_vld[i] && m_pn[i] == pn) return 1;
    return 0;
  endfunction

  function automatic void m_fill(input logic [19:0] pn);
    for (int i = 0; i < 4; i++) if (!m_vld[i]) begin m_vld[i] = 1; m_pn[i] = pn; return; end
    m_pn[m_rr] = pn;
    m_rr = (m_rr + 1) % 4;
  endfunction

  task automatic set_base(input bit b);
    @(negedge clk);
    base_sel  = b;
    ptbase    = b ? BASE_B : BASE_A;
    ptbase_wr = 1'b1;
    @(negedge clk);
    ptbase_wr = 1'b0;
    m_flush();
  endtask

  // mode 0 plain, 1 flush with request, 2 flush mid-walk, 3 stray request mid-walk
  // want: -1 model only, 0 expect miss, 1 expect hit
  task automatic xlate(input logic [31:0] la, input int mode, input int want,
                       input int lat, input int stall);
    logic [19:0] pn;
    logic [31:0] pte, exp_pa;
    bit          exp_hit, present;
    int          r0, n;
    pn = la[31:12];
    lat_knob = lat;
    stall_knob = stall;
    if (mode == 1) m_flush();
    exp_hit = m_hit(pn);
    pte     = pte_of(base_sel, pn);
    present = pte[0];
    exp_pa  = present ? {pte[31:12], la[11:0]} : 32'h0;
    if (!exp_hit && present && mode != 2) m_fill(pn);
    if (mode == 2) m_flush();
    @(negedge clk);
    check(req_ready === 1'b1, "R8 ready when idle", {31'b0, req_ready}, 32'h1);
    r0 = reads;
    req_valid = 1'b1;
    req_laddr = la;
    flush = (mode == 1);
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    while (done !== 1'b1 && n < 400) begin
      flush = (mode == 2 && n == 2);
      if (mode == 3) begin
        req_valid = (n == 2);
        req_laddr = la ^ 32'h0005_0000;
        if (n == 2) check(req_ready === 1'b0, "R8 busy not ready", {31'b0, req_ready}, 32'h0);
      end
      @(negedge clk);
      n++;
    end
    flush = 1'b0;
    req_valid = 1'b0;
    check(done === 1'b1, "R9 walk completes", {31'b0, done}, 32'h1);
    check(done_paddr === exp_pa, present ? "R3 physical address" : "R4 fault address zero",
          done_paddr, exp_pa);
    check(done_fault === !present, "R4 fault flag", {31'b0, done_fault}, {31'b0, !present});
    if (exp_hit) begin
      check(n == 1, "R1 hit latency", n, 1);
      check(reads == r0, "R1 hit without memory read", reads - r0, 0);
    end else begin
      check(reads == r0 + 1, "R2 one read per miss", reads - r0, 1);
      check(hs_addr === ((base_sel ? BASE_B : BASE_A) + {10'b0, pn, 2'b00}),
            "R2 entry address", hs_addr, (base_sel ? BASE_B : BASE_A) + {10'b0, pn, 2'b00});
    end
    if (want >= 0)
      check(exp_hit == bit'(want) && (reads == r0) == bit'(want), "R6 R7 expected hit/miss",
            reads - r0, want ? 0 : 1);
    @(negedge clk);
    check(done === 1'b0, "R1 R8 single done pulse", {31'b0, done}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_laddr = '0; ptbase = BASE_A;
    ptbase_wr = 1'b0; flush = 1'b0; mem_req_ready = 1'b0;
    m_flush();
    repeat (3) @(negedge clk);
    check(done === 1'b0, "R10 done low in reset", {31'b0, done}, 32'h0);
    check(mem_req_valid === 1'b0, "R10 no read in reset", {31'b0, mem_req_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready === 1'b1, "R10 ready after reset", {31'b0, req_ready}, 32'h1);
    check(done === 1'b0, "R10 done low after reset", {31'b0, done}, 32'h0);

    // R10: cache starts empty
    xlate(32'h0000_0123, 0, 0, 0, 0);
    set_base(0);

    // sweeps over both tables, offsets, latencies and stalls (R1..R5, R9)
    for (int b = 0; b < 2; b++) begin
      set_base(bit'(b));
      for (int rep = 0; rep < 3; rep++) begin
        for (int pg = 0; pg < 5; pg++) begin
          logic [11:0] off;
          off = (rep == 0) ? 12'h000 : (rep == 1) ? 12'hFFF : 12'(pg * 12'h123 + 1);
          xlate({20'(pg), off}, 0, -1, (pg + rep) % 4, pg % 3);
        end
      end
    end

    // R6: empty entries first, then round robin from entry 0
    set_base(0);
    xlate({20'd100, 12'h010}, 0, 0, 1, 0);
    xlate({20'd101, 12'h020}, 0, 0, 0, 1);
    xlate({20'd102, 12'h030}, 0, 0, 2, 0);
    xlate({20'd104, 12'h040}, 0, 0, 0, 0);
    xlate({20'd105, 12'h050}, 0, 0, 1, 2);
    xlate({20'd101, 12'h060}, 0, 1, 0, 0);
    xlate({20'd100, 12'h070}, 0, 0, 0, 0);
    xlate({20'd102, 12'h080}, 0, 1, 0, 0);
    xlate({20'd101, 12'h090}, 0, 0, 3, 0);

    // R7: flush in the request cycle, and flush during a walk
    xlate({20'd104, 12'h0A0}, 0, 1, 0, 0);
    xlate({20'd104, 12'h0B0}, 1, 0, 0, 0);
    xlate({20'd104, 12'h0C0}, 0, 1, 0, 0);
    xlate({20'd7,   12'h0D0}, 2, 0, 6, 1);
    xlate({20'd7,   12'h0E0}, 0, 0, 0, 0);
    xlate({20'd7,   12'h0F0}, 0, 1, 0, 0);

    // R8: stray request during a walk is dropped
    xlate({20'd9, 12'h111}, 3, 0, 6, 2);
    check(reads > 0 && mem_req_valid === 1'b0, "R8 no stray walk", {31'b0, mem_req_valid}, 32'h0);
    xlate({20'd9, 12'h222}, 0, 1, 0, 0);

    // R4: a missing page is fetched again every time
    xlate({20'd3, 12'h333}, 0, 0, 1, 0);
    xlate({20'd3, 12'h334}, 0, 0, 0, 0);

    // R11: same page, new table, new frame
    xlate({20'd1, 12'h456}, 0, -1, 0, 0);
    check(done_paddr === 32'h0A5C_2456, "R11 frame under first table", done_paddr, 32'h0A5C_2456);
    set_base(1);
    xlate({20'd1, 12'h456}, 0, 0, 0, 0);
    check(done_paddr === 32'h1234_6456, "R11 frame under second table", done_paddr, 32'h1234_6456);

    repeat (3) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule